// File: doc/BRIEF.md
# Timing-Pulse Sequencer

This block paces instruction execution in a microsequenced processor. Each instruction runs as a chain of subsequences. Every subsequence is twelve timing pulses long, and each pulse lasts one clock. A start strobe, sampled while the block is idle, launches a chain. The chain depends on a decoded instruction class. A single-subsequence instruction, such as a transfer of control, runs one subsequence. A multiply runs a head subsequence, then a step subsequence repeated six times, then a tail subsequence.

For every combination of subsequence and timing pulse, a small read-only table drives five control strobes. Each strobe stands for one datapath transfer: memory onto the bus, bus into the accumulator, bus into the multiplier register, a shift of the product pair, or bus into the next-instruction register. The table is read synchronously with next-state addressing, so all outputs come from registers.

An instruction-done pulse marks the last timing pulse of the last subsequence. The block is idle in the cycle after that pulse and accepts a new start there.

Top module: `tpulse_sequencer`

## Requirements
- R1: A start sampled high at a clock edge while idle makes `tp_onehot` bit 0 (TP1) high in the following cycle. After that, bit i (TP i+1) is followed in the next cycle by bit i+1, through bit 11 (TP12).
- R2: `tp_onehot` never has more than one bit set, and it is all zero while idle.
- R3: Only `instr_class` = 2'b01 selects multiply. The codes 2'b00, 2'b10 and 2'b11 run a single subsequence with `subseq_id` = 0, which lasts exactly 12 cycles.
- R4: A multiply shows `subseq_id` 1 for one subsequence, then 2 for six consecutive subsequences, then 3 for one subsequence. The whole chain lasts 96 cycles.
- R5: `instr_done` is high for exactly one cycle per instruction: the TP12 cycle of the last subsequence, which is subsequence id 0 or 3.
- R6: The cycle after `instr_done` is idle, and a start sampled in that idle cycle launches the next instruction at once.
- R7: While an instruction is running, including its done cycle, `start` and changes of `instr_class` have no effect on the running chain and do not launch another one.
- R8: A synchronous active-high `rst` makes the block idle on the next cycle: `tp_onehot`, `subseq_id`, `ctl_strobe` and `instr_done` are all zero.
- R9: `ctl_strobe` follows a fixed table. Bit 0 is memory-to-bus, bit 1 is bus-to-accumulator, bit 2 is bus-to-multiplier, bit 3 is shift, and bit 4 is bus-to-next-instruction. The entries are:
  - subsequence 0: bit 0 at TP2, bit 1 at TP6, bit 4 at TP11;
  - subsequence 1: bit 0 at TP2, bit 2 at TP6;
  - subsequence 2: bit 3 at TP4 and at TP8, bit 1 at TP10;
  - subsequence 3: bit 1 at TP6, bit 4 at TP11;
  - every other entry, and every idle cycle: zero.
- R10: `subseq_id` is constant across the twelve pulses of a subsequence and reads 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled only while idle |
| instr_class | input | 2 | Decoded class; 2'b01 selects multiply |
| tp_onehot | output | 12 | One-hot timing pulse, bit 0 = TP1 |
| subseq_id | output | 2 | Current subsequence: 0 single, 1 multiply head, 2 multiply step, 3 multiply tail |
| instr_done | output | 1 | High during TP12 of the final subsequence |
| ctl_strobe | output | 5 | Control strobes from the pulse table |

## Verification
The properties assume that `start` and `instr_class` hold known values from the first clock edge on. They also assume that reset is applied at time zero, so the outputs hold defined values before any launch.

The stimulus drives both inputs from time zero and changes them only at falling clock edges. It holds `rst` high for the first cycles. It then sweeps every class code, both with a single-cycle start and with start held high through the whole run. In the held runs it also changes the class mid-run. This covers back-to-back launches and ignored starts without ever leaving the assumed input space.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    SQ_SINGLE   = 2'd0,
    SQ_MUL_HEAD = 2'd1,
    SQ_MUL_STEP = 2'd2,
    SQ_MUL_TAIL = 2'd3
  } subseq_e;

  localparam int          SQ_W         = 2;
  localparam int          CLS_W        = 2;
  localparam logic [1:0]  CLS_MULTIPLY = 2'b01;

  localparam int NUM_CP         = 5;
  localparam int CP_MEM_TO_BUS  = 0;
  localparam int CP_BUS_TO_ACC  = 1;
  localparam int CP_BUS_TO_MULT = 2;
  localparam int CP_SHIFT_PAIR  = 3;
  localparam int CP_BUS_TO_NEXT = 4;

  // Strobe pattern for one table entry; tp is zero-based (0 = TP1).
  function automatic logic [NUM_CP-1:0] cp_rule(logic [SQ_W-1:0] sq, int tp);
    logic [NUM_CP-1:0] s;
    s = '0;
    case (sq)
      SQ_SINGLE: begin
        if (tp == 1)  s[CP_MEM_TO_BUS]  = 1'b1;
        if (tp == 5)  s[CP_BUS_TO_ACC]  = 1'b1;
        if (tp == 10) s[CP_BUS_TO_NEXT] = 1'b1;
      end
      SQ_MUL_HEAD: begin
        if (tp == 1)  s[CP_MEM_TO_BUS]  = 1'b1;
        if (tp == 5)  s[CP_BUS_TO_MULT] = 1'b1;
      end
      SQ_MUL_STEP: begin
        if (tp == 3 || tp == 7) s[CP_SHIFT_PAIR] = 1'b1;
        if (tp == 9)  s[CP_BUS_TO_ACC]  = 1'b1;
      end
      default: begin
        if (tp == 5)  s[CP_BUS_TO_ACC]  = 1'b1;
        if (tp == 10) s[CP_BUS_TO_NEXT] = 1'b1;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tps_chain_ctrl.sv
module tps_chain_ctrl
  import tps_pkg::*;
#(
  parameter int NUM_TP    = 12,
  parameter int MP_REPEAT = 6,
  parameter int TP_W      = $clog2(NUM_TP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CLS_W-1:0]     instr_class,
  output logic                 nxt_busy,
  output logic [TP_W-1:0]      nxt_tp,
  output subseq_e              nxt_sq,
  output subseq_e              sq_q,
  output logic                 done_q
);

  localparam int              REP_W   = $clog2(MP_REPEAT + 1);
  localparam logic [TP_W-1:0] TP_LAST = TP_W'(NUM_TP - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(MP_REPEAT - 1);

  logic              busy_q;
  logic [TP_W-1:0]   tp_q;
  logic [REP_W-1:0]  rep_q, nxt_rep;
  logic              nxt_done;

  always_comb begin
    nxt_busy = busy_q;
    nxt_tp   = tp_q;
    nxt_sq   = sq_q;
    nxt_rep  = rep_q;
    if (!busy_q) begin
      if (start) begin
        nxt_busy = 1'b1;
        nxt_tp   = '0;
        nxt_rep  = '0;
        nxt_sq   = (instr_class == CLS_MULTIPLY) ? SQ_MUL_HEAD : SQ_SINGLE;
      end
    end else if (tp_q != TP_LAST) begin
      nxt_tp = tp_q + 1'b1;
    end else begin
      nxt_tp = '0;
      case (sq_q)
        SQ_MUL_HEAD: begin
          nxt_sq  = SQ_MUL_STEP;
          nxt_rep = '0;
        end
        SQ_MUL_STEP: begin
          if (rep_q == REP_LAST) nxt_sq = SQ_MUL_TAIL;
          else                   nxt_rep = rep_q + 1'b1;
        end
        default: begin
          nxt_busy = 1'b0;
          nxt_sq   = SQ_SINGLE;
        end
      endcase
    end
    nxt_done = nxt_busy && (nxt_tp == TP_LAST) &&
               (nxt_sq == SQ_SINGLE || nxt_sq == SQ_MUL_TAIL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tp_q   <= '0;
      sq_q   <= SQ_SINGLE;
      rep_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= nxt_busy;
      tp_q   <= nxt_tp;
      sq_q   <= nxt_sq;
      rep_q  <= nxt_rep;
      done_q <= nxt_done;
    end
  end

endmodule

// File: rtl/tps_tp_ring.sv
module tps_tp_ring #(
  parameter int NUM_TP = 12,
  parameter int TP_W   = $clog2(NUM_TP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_busy,
  input  logic [TP_W-1:0]   nxt_tp,
  output logic [NUM_TP-1:0] tp_onehot
);

  for (genvar i = 0; i < NUM_TP; i++) begin : g_tp
    always_ff @(posedge clk) begin
      if (rst) tp_onehot[i] <= 1'b0;
      else     tp_onehot[i] <= nxt_busy && (nxt_tp == TP_W'(i));
    end
  end

endmodule

// File: rtl/tps_cp_rom.sv
module tps_cp_rom
  import tps_pkg::*;
#(
  parameter int TP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [SQ_W-1:0]   rd_sq,
  input  logic [TP_W-1:0]   rd_tp,
  output logic [NUM_CP-1:0] cp_q
);

  localparam int ADDR_W = SQ_W + TP_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [NUM_CP-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = cp_rule(SQ_W'(i >> TP_W), i % (1 << TP_W));
  end

  always_ff @(posedge clk) begin
    if (rst)        cp_q <= '0;
    else if (rd_en) cp_q <= rom[{rd_sq, rd_tp}];
    else            cp_q <= '0;
  end

endmodule

// File: rtl/tpulse_sequencer.sv
module tpulse_sequencer
  import tps_pkg::*;
#(
  parameter int NUM_TP    = 12,
  parameter int MP_REPEAT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        instr_class,
  output logic [NUM_TP-1:0] tp_onehot,
  output logic [1:0]        subseq_id,
  output logic              instr_done,
  output logic [4:0]        ctl_strobe
);

  localparam int TP_W = $clog2(NUM_TP);

  logic            nxt_busy;
  logic [TP_W-1:0] nxt_tp;
  subseq_e         nxt_sq;
  subseq_e         sq_q;

  tps_chain_ctrl #(
    .NUM_TP(NUM_TP), .MP_REPEAT(MP_REPEAT), .TP_W(TP_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .instr_class(instr_class),
    .nxt_busy(nxt_busy), .nxt_tp(nxt_tp), .nxt_sq(nxt_sq),
    .sq_q(sq_q), .done_q(instr_done)
  );

  tps_tp_ring #(.NUM_TP(NUM_TP), .TP_W(TP_W)) u_ring (
    .clk(clk), .rst(rst), .nxt_busy(nxt_busy), .nxt_tp(nxt_tp),
    .tp_onehot(tp_onehot)
  );

  tps_cp_rom #(.TP_W(TP_W)) u_rom (
    .clk(clk), .rst(rst), .rd_en(nxt_busy), .rd_sq(nxt_sq),
    .rd_tp(nxt_tp), .cp_q(ctl_strobe)
  );

  assign subseq_id = sq_q;

endmodule

// File: rtl/tps_sequencer_checker.sv
module tps_sequencer_checker #(
  parameter int NUM_TP = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [NUM_TP-1:0] tp_onehot,
  input logic [1:0]        subseq_id,
  input logic              instr_done,
  input logic [4:0]        ctl_strobe
);

  p_launch_r1: assert property (@(posedge clk) disable iff (rst)
    (tp_onehot == '0 && start) |=> tp_onehot == NUM_TP'(1));

  p_advance_r1: assert property (@(posedge clk) disable iff (rst)
    (tp_onehot != '0 && !tp_onehot[NUM_TP-1]) |=> tp_onehot == ($past(tp_onehot) << 1));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tp_onehot));

  p_head_to_step_r4: assert property (@(posedge clk) disable iff (rst)
    (tp_onehot[NUM_TP-1] && subseq_id == 2'd1) |=> subseq_id == 2'd2);

  p_done_at_last_r5: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (tp_onehot[NUM_TP-1] && (subseq_id == 2'd0 || subseq_id == 2'd3)));

  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> tp_onehot == '0);

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (tp_onehot != '0 && !instr_done) |=> tp_onehot != '0);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (tp_onehot == '0) |-> (ctl_strobe == '0 && subseq_id == 2'd0 && !instr_done));

  p_sq_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (tp_onehot != '0 && !tp_onehot[NUM_TP-1]) |=> $stable(subseq_id));

endmodule

bind tpulse_sequencer tps_sequencer_checker #(.NUM_TP(NUM_TP)) u_chk (
  .clk(clk), .rst(rst), .start(start), .tp_onehot(tp_onehot),
  .subseq_id(subseq_id), .instr_done(instr_done), .ctl_strobe(ctl_strobe)
);

// File: tb/tpulse_sequencer_bench.sv
`timescale 1ns/1ps
module tpulse_sequencer_bench;

  localparam int NTP  = 12;
  localparam int NREP = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [1:0]      instr_class = 2'b00;
  logic [NTP-1:0]  tp_onehot;
  logic [1:0]      subseq_id;
  logic            instr_done;
  logic [4:0]      ctl_strobe;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  tpulse_sequencer u_tpulse_sequencer (
    .clk(clk), .rst(rst), .start(start), .instr_class(instr_class),
    .tp_onehot(tp_onehot), .subseq_id(subseq_id),
    .instr_done(instr_done), .ctl_strobe(ctl_strobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Strobe table from R9, written with 1-based pulse numbers.
  function automatic int exp_strobe(int sq, int tpn);
    int s = 0;
    case (sq)
      0: begin if (tpn == 2) s |= 1; if (tpn == 6) s |= 2; if (tpn == 11) s |= 16; end
      1: begin if (tpn == 2) s |= 1; if (tpn == 6) s |= 4; end
      2: begin if (tpn == 4 || tpn == 8) s |= 8; if (tpn == 10) s |= 2; end
      default: begin if (tpn == 6) s |= 2; if (tpn == 11) s |= 16; end
    endcase
    return s;
  endfunction

  task automatic check_idle(input string req);
    chk(tp_onehot == '0, req, int'(tp_onehot), 0);
    chk(subseq_id == 2'd0 && ctl_strobe == '0 && !instr_done, req,
        int'({subseq_id, ctl_strobe, instr_done}), 0);
  endtask

  // Called at a falling edge of an idle cycle; returns at the falling edge
  // of the cycle after the done cycle. hold keeps start high throughout.
  task automatic run(input logic [1:0] cls, input bit hold);
    int total;
    int cycles;
    bit is_mul;
    is_mul = (cls == 2'b01);
    total  = is_mul ? NTP * (NREP + 2) : NTP;
    cycles = 0;
    instr_class = cls;
    start = 1'b1;
    @(negedge clk);
    for (int c = 0; c < total; c++) begin
      int tpn = (c % NTP) + 1;
      int sub = c / NTP;
      int esq = !is_mul ? 0 : (sub == 0 ? 1 : (sub <= NREP ? 2 : 3));
      if (!hold) start = 1'b0;
      if (hold && c == 5) instr_class = cls ^ 2'b01;   // R7: class change ignored
      chk(tp_onehot == NTP'(1) << (tpn - 1), "R1 pulse order",
          int'(tp_onehot), 1 << (tpn - 1));
      chk(int'(subseq_id) == esq, is_mul ? "R4 multiply subsequence" : "R3 single subsequence",
          int'(subseq_id), esq);
      chk(int'(ctl_strobe) == exp_strobe(esq, tpn), "R9 strobe table",
          int'(ctl_strobe), exp_strobe(esq, tpn));
      chk(instr_done == (c == total - 1), "R5 done timing",
          int'(instr_done), int'(c == total - 1));
      if (tp_onehot != '0) cycles++;
      @(negedge clk);
    end
    chk(cycles == total, is_mul ? "R4 length 96" : "R3 length 12", cycles, total);
    check_idle(hold ? "R7 start ignored in done cycle" : "R6 idle after done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R8 reset state");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R2 idle without start");

    run(2'b00, 1'b0);
    run(2'b01, 1'b0);
    run(2'b10, 1'b1);
    run(2'b01, 1'b1);   // R6: launched in the idle cycle right after done
    run(2'b11, 1'b1);
    run(2'b01, 1'b0);
    run(2'b00, 1'b0);

    // R8: reset in the middle of a multiply.
    instr_class = 2'b01;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(tp_onehot != '0, "R8 running before reset", int'(tp_onehot), 1);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R8 reset mid-run");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R8 stays idle after reset");
    run(2'b00, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule